// File: doc/BRIEF.md
# Colour Lookup Write Buffer

This block sits between a host bus and a 256-entry colour lookup RAM that feeds the pixel pipeline. The host presents an index and a packed colour word. The pair is placed in a small queue instead of going to the RAM at once. Queued entries are copied into the RAM only while the raster position lies inside a programmed update window, which is normally set to match horizontal or vertical blanking. As a result, the pixel lookup port never has a write land on it while it is in use during active video.

The host reads a free-slot count before it writes. A count of zero means the queue is full and the host must hold off. A write made while the queue is full is discarded, and a sticky overflow flag records that this happened. The pixel side has one registered lookup port.

Top module: `cmap_wbuf`

## Requirements
- R1: A write whose 9-bit index is above 255 (bit 8 set) is discarded. It changes neither the queue, the free count, the overflow flag nor the RAM.
- R2: A colour word holds red in bits 31:24, green in bits 23:16 and blue in bits 15:8. Bits 7:0 are not stored, and a lookup always returns them as zero.
- R3: `free_cnt` equals DEPTH (8) minus the number of queued entries. It changes on the clock edge that performs a push or a pop, so it is visible from the following cycle.
- R4: A valid write made while the queue is full (`free_cnt` = 0 before the edge) is discarded and sets `overflow`. `overflow` then stays at 1 until reset.
- R5: The update window is open when `hpos` lies in the horizontal range or `vpos` lies in the vertical range. Each range is [on, off). When on > off, the range wraps past zero, so it is pos >= on or pos < off. No RAM write happens while the window is closed.
- R6: While the window is open, at most one entry is written to the RAM per clock, in arrival order. If the same index is written twice, the later value is the one that remains. A push and a pop may happen on the same edge.
- R7: The lookup port returns `ram[rd_idx]` one clock after `rd_idx` is presented. If a drain writes the same index on that same edge, the port returns the value from before the write.
- R8: After reset, `free_cnt` is 8 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 9 | Host write index (values above 255 are rejected) |
| wr_data | input | 32 | Packed colour word R:G:B:unused |
| hpos | input | 12 | Current horizontal raster position |
| vpos | input | 12 | Current vertical raster position |
| h_on | input | 12 | Horizontal window start (inclusive) |
| h_off | input | 12 | Horizontal window end (exclusive) |
| v_on | input | 12 | Vertical window start (inclusive) |
| v_off | input | 12 | Vertical window end (exclusive) |
| rd_idx | input | 8 | Pixel lookup index |
| rd_data | output | 32 | Registered lookup result, low byte zero |
| free_cnt | output | 4 | Number of free queue slots |
| overflow | output | 1 | Sticky flag: a write was dropped while the queue was full |

## Verification
Several stimulus patterns are used, and each one separates a different kind of fault:

- A burst of host writes with the window held closed fills the queue. The write after that must raise the overflow flag. This shows whether the full test and the drop logic are correct.
- Opening the window through the horizontal range alone, through a range that wraps past zero, and through the vertical range alone checks each branch of the window decode on its own.
- Writing the same index twice before a drain, and streaming writes while the window is open, show whether entries drain in order and whether a push and a pop on the same edge keep the count right.
- Out-of-range indices, and reads of an index on the same edge that drains it, check that bad writes are rejected and that a lookup returns the value from before the write.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
  localparam int IDX_W   = 8;
  localparam int COL_W   = 24;
  localparam int POS_W   = 12;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [COL_W-1:0] col;
  } cmap_ent_t;

  // Range test with wrap: [on, off) or, when on > off, the complement of [off, on)
  function automatic logic pos_in_range(input logic [POS_W-1:0] p,
                                        input logic [POS_W-1:0] on,
                                        input logic [POS_W-1:0] off);
    if (on <= off) return (p >= on) && (p < off);
    else           return (p >= on) || (p < off);
  endfunction

  function automatic logic [31:0] unpack_col(input logic [COL_W-1:0] c);
    return {c, 8'h00};
  endfunction
endpackage

// File: rtl/cmap_win.sv
module cmap_win
  import cmap_pkg::*;
(
  input  logic [POS_W-1:0] hpos,
  input  logic [POS_W-1:0] vpos,
  input  logic [POS_W-1:0] h_on,
  input  logic [POS_W-1:0] h_off,
  input  logic [POS_W-1:0] v_on,
  input  logic [POS_W-1:0] v_off,
  output logic             open
);
  logic [1:0] axis_hit;
  logic [POS_W-1:0] pos_a [2];
  logic [POS_W-1:0] on_a  [2];
  logic [POS_W-1:0] off_a [2];

  assign pos_a[0] = hpos;  assign on_a[0] = h_on;  assign off_a[0] = h_off;
  assign pos_a[1] = vpos;  assign on_a[1] = v_on;  assign off_a[1] = v_off;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    assign axis_hit[g] = pos_in_range(pos_a[g], on_a[g], off_a[g]);
  end

  assign open = |axis_hit;
endmodule

// File: rtl/cmap_wfifo.sv
module cmap_wfifo
  import cmap_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  cmap_ent_t push_ent,
  input  logic      pop,
  output cmap_ent_t head,
  output logic      empty,
  output logic      full,
  output logic [CW-1:0] count
);
  cmap_ent_t       store [DEPTH];
  logic [AW-1:0]   wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = store[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) begin
        store[wp] <= push_ent;
        wp        <= bump(wp);
      end
      if (pop) rp <= bump(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cmap_lut.sv
module cmap_lut
  import cmap_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int AW = $clog2(ENTRIES)
)(
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [COL_W-1:0] wcol,
  input  logic [AW-1:0]    raddr,
  output logic [COL_W-1:0] rcol
);
  logic [COL_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wcol;
    rcol <= mem[raddr];
  end
endmodule

// File: rtl/cmap_wbuf.sv
module cmap_wbuf
  import cmap_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [8:0]    wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [11:0]   hpos,
  input  logic [11:0]   vpos,
  input  logic [11:0]   h_on,
  input  logic [11:0]   h_off,
  input  logic [11:0]   v_on,
  input  logic [11:0]   v_off,
  input  logic [7:0]    rd_idx,
  output logic [31:0]   rd_data,
  output logic [CW-1:0] free_cnt,
  output logic          overflow
);
  // Named internal events for the checker
  logic      win_active;
  logic      idx_ok;
  logic      push_req;
  logic      push_go;
  logic      push_drop;
  logic      lut_we;
  logic      q_empty, q_full;
  logic [CW-1:0] q_count;
  cmap_ent_t q_head, q_in;
  logic [COL_W-1:0] rcol;

  cmap_win u_win (
    .hpos(hpos), .vpos(vpos), .h_on(h_on), .h_off(h_off),
    .v_on(v_on), .v_off(v_off), .open(win_active)
  );

  assign idx_ok    = ~wr_idx[8];
  assign push_req  = wr_en & idx_ok;
  assign push_go   = push_req & ~q_full;
  assign push_drop = push_req &  q_full;
  assign lut_we    = win_active & ~q_empty;
  assign q_in.idx  = wr_idx[7:0];
  assign q_in.col  = wr_data[31:8];

  cmap_wfifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_go), .push_ent(q_in),
    .pop(lut_we), .head(q_head), .empty(q_empty), .full(q_full),
    .count(q_count)
  );

  cmap_lut #(.ENTRIES(256)) u_lut (
    .clk(clk), .we(lut_we), .waddr(q_head.idx), .wcol(q_head.col),
    .raddr(rd_idx), .rcol(rcol)
  );

  assign rd_data  = unpack_col(rcol);
  assign free_cnt = CW'(DEPTH) - q_count;

  always_ff @(posedge clk) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (push_drop) overflow <= 1'b1;
  end
endmodule

// File: rtl/cmap_wbuf_chk.sv
module cmap_wbuf_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
)(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [8:0]    wr_idx,
  input logic [CW-1:0] free_cnt,
  input logic          overflow,
  input logic          lut_we,
  input logic          win_active
);
  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we |-> win_active);  // R5
  AST_FREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(DEPTH));  // R3
  AST_DRAIN_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we |-> free_cnt < CW'(DEPTH));  // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);  // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_idx[8] && free_cnt == '0 && !lut_we) |=> (free_cnt == '0 && overflow));  // R4
  AST_BAD_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx[8] && !lut_we) |=> $stable(free_cnt));  // R1
  AST_ONE_POP_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt != '0 && !wr_en) |=> free_cnt <= $past(free_cnt) + 1'b1);  // R6
endmodule

bind cmap_wbuf cmap_wbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .free_cnt(free_cnt), .overflow(overflow), .lut_we(lut_we),
  .win_active(win_active)
);

// File: tb/cmap_wbuf_tb.sv
module cmap_wbuf_tb;
  localparam int DEPTH = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [8:0]  wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic [11:0] hpos = 0, vpos = 0;
  logic [11:0] h_on = 100, h_off = 120, v_on = 480, v_off = 490;
  logic [7:0]  rd_idx = 0;
  logic [31:0] rd_data;
  logic [3:0]  free_cnt;
  logic        overflow;

  int tests = 0, fails = 0;
  bit done = 0;

  cmap_wbuf #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .hpos(hpos), .vpos(vpos), .h_on(h_on), .h_off(h_off), .v_on(v_on), .v_off(v_off),
    .rd_idx(rd_idx), .rd_data(rd_data), .free_cnt(free_cnt), .overflow(overflow)
  );

  always #5 clk = ~clk;

  // Reference model
  int          mq_idx[$];
  logic [31:0] mq_col[$];
  logic [31:0] m_ram [256];
  bit          m_known [256];
  bit          m_ovf = 0;
  bit          rd_valid = 0;
  logic [31:0] rd_exp = 0;

  function automatic bit in_win(int p, int on, int off);
    if (on > off) return !(p >= off && p < on);
    return p >= on && p < off;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(string tag, bit en, int idx, logic [31:0] d, int ridx);
    bit open, take;
    int sz;
    wr_en = en; wr_idx = idx[8:0]; wr_data = d; rd_idx = ridx[7:0];
    @(posedge clk);
    open = in_win(hpos, h_on, h_off) || in_win(vpos, v_on, v_off);
    sz = mq_idx.size();
    rd_valid = m_known[ridx];
    rd_exp = m_ram[ridx];
    take = en && idx < 256;
    if (take && sz == DEPTH) m_ovf = 1;
    if (open && sz > 0) begin
      m_ram[mq_idx[0]] = mq_col[0];
      m_known[mq_idx[0]] = 1;
      void'(mq_idx.pop_front());
      void'(mq_col.pop_front());
    end
    if (take && sz < DEPTH) begin
      mq_idx.push_back(idx);
      mq_col.push_back({d[31:8], 8'h00});
    end
    @(negedge clk);
    check({tag, " R3 free"}, 32'(free_cnt), 32'(DEPTH - mq_idx.size()));
    check({tag, " R4 overflow"}, 32'(overflow), 32'(m_ovf));
    if (rd_valid) check({tag, " R7 lookup"}, rd_data, rd_exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_known[i] = 0;
    hpos = 10; vpos = 10;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset free", 32'(free_cnt), 32'(DEPTH));
    check("R8 reset ovf", 32'(overflow), 0);

    // R4: fill with window closed, then overflow
    for (int i = 0; i < DEPTH; i++) cyc("R4 fill", 1, i, 32'h11223300 + i * 32'h01010100 + 32'hAB, 0);
    cyc("R4 full write", 1, 50, 32'hDEADBEEF, 0);
    cyc("R4 idle", 0, 0, 0, 0);

    // R5 horizontal window opens, R2 low byte zero on reads
    hpos = 105;
    for (int i = 0; i < DEPTH + 2; i++) cyc("R5 hdrain", 0, 0, 0, i % DEPTH);
    hpos = 10;
    for (int i = 0; i < DEPTH; i++) cyc("R2 read", 0, 0, 0, i);
    cyc("R2 unwritten 50", 0, 0, 0, 50);
    check("R2 low byte", {24'h0, rd_data[7:0]}, 0);

    // R1: out-of-range index ignored
    cyc("R1 bad idx", 1, 256 + 5, 32'hFFFFFFFF, 5);
    cyc("R1 bad idx", 1, 511, 32'hFFFFFFFF, 5);
    hpos = 110;
    cyc("R1 after", 0, 0, 0, 5);
    cyc("R1 after", 0, 0, 0, 5);
    check("R1 idx5 kept", rd_data, 32'h16273800);

    // R5 wrapping horizontal range
    h_on = 200; h_off = 20; hpos = 100;
    cyc("R5 wrap closed", 1, 20, 32'hA0A0A000, 20);
    cyc("R5 wrap closed", 1, 21, 32'hB0B0B000, 21);
    cyc("R5 wrap closed", 0, 0, 0, 20);
    hpos = 5;
    cyc("R5 wrap open", 0, 0, 0, 20);
    cyc("R5 wrap open", 0, 0, 0, 20);
    cyc("R5 wrap read", 0, 0, 0, 21);
    hpos = 250;
    cyc("R5 wrap high", 1, 22, 32'hC0C0C0FF, 22);
    cyc("R5 wrap high", 0, 0, 0, 22);

    // R5 vertical-only window
    hpos = 100;
    cyc("R5 v closed", 1, 30, 32'h12345678, 30);
    cyc("R5 v closed", 0, 0, 0, 30);
    vpos = 485;
    cyc("R5 v open", 0, 0, 0, 30);
    cyc("R5 v read", 0, 0, 0, 30);
    vpos = 10;

    // R6 ordering: same index twice
    cyc("R6 order", 1, 40, 32'h01010100, 40);
    cyc("R6 order", 1, 40, 32'h02020200, 40);
    hpos = 0;
    cyc("R6 drain", 0, 0, 0, 40);
    cyc("R6 drain", 0, 0, 0, 40);
    cyc("R6 read", 0, 0, 0, 40);
    check("R6 last wins", rd_data, 32'h02020200);

    // R6 simultaneous push/pop with window open; R7 read during drain
    for (int i = 0; i < 6; i++) cyc("R6 stream", 1, 60 + i, 32'h00100000 * (i + 1), 60 + i);
    cyc("R7 same-edge", 1, 60, 32'h77777700, 60);
    cyc("R7 same-edge", 0, 0, 0, 60);
    cyc("R7 after", 0, 0, 0, 60);
    check("R7 new value", rd_data, 32'h77777700);

    // R4 flag persists
    for (int i = 0; i < 4; i++) cyc("R4 sticky", 0, 0, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule